// File: doc/BRIEF.md
# Processor Reset and Watchdog Supervisor

This block is the digital core of a processor supervisor. It takes a supply-good flag that an analog comparator has already produced, a backup-power flag, and a watchdog strobe already decoded into low, high or mid/floating. From these it produces a processor reset in both polarities, a supply status, a sticky watchdog-timeout status and a gated memory chip-enable. All timing is counted in ticks of a timebase enable. These ticks come either from an external clock or from a nominal 10.24 kHz internal oscillator.

After the supply recovers, reset is held for a fixed number of ticks. The watchdog then allows a long grace period. Once software produces its first strobe edge, the watchdog switches to the normal period that the oscillator-mode and period-select inputs choose. A missed strobe causes a reset pulse and drops the timeout status. The status stays low until the next strobe edge. A strobe held at the mid level switches the watchdog off.

Top module: `proc_supervisor`

## Requirements
- R1: While `supply_ok` is 0 or `on_backup` is 1, `rst_out_n` is 0 in the same cycle. After the supply is good again, `rst_out_n` stays 0 for exactly `RST_TICKS` ticks and then goes to 1.
- R2: `rst_out` is always the complement of `rst_out_n`.
- R3: A strobe change between low (`2'b00`) and high (`2'b01`) restarts the watchdog count. The change is seen on the tick where the level differs from the level of the previous tick. The count also restarts when any reset ends.
- R4: If no strobe edge arrives within the active timeout, the block asserts reset for `RST_TICKS` ticks and drives `wd_ok` to 0 on the same tick.
- R5: `wd_ok` stays 0 after a timeout until the next strobe edge outside reset. While the supply is bad, `wd_ok` is forced to 1, and the flag is cleared.
- R6: A strobe at the mid level (`2'b10` or `2'b11`) disables the watchdog. No timeout reset occurs, and `wd_ok` is 1.
- R7: After any reset ends, the long timeout applies until the first strobe edge. Edges that arrive while reset is active do not shorten it.
- R8: With `osc_ext`=1, the normal timeout is `EXT_SHORT` ticks and the long one is `EXT_LONG` ticks. With `osc_ext`=0, the long timeout is `INT_LONG`, and the normal timeout is `INT_SHORT` when `period_sel`=0 or `INT_LONG` when `period_sel`=1.
- R9: `ce_out_n` equals `ce_in_n` while the supply is good. It is 1 while `supply_ok` is 0.
- R10: While `on_backup` is 1, reset is asserted, `wd_ok` is 1, `ce_out_n` is 1 and `low_line_n` is 0. The strobe and the oscillator selects have no effect.
- R11: With a constant strobe, timeout resets repeat once every long period plus the reset width.
- R12: `low_line_n` is 1 exactly when `supply_ok` is 1 and `on_backup` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one per oscillator period |
| supply_ok | input | 1 | Compared supply flag, 1 = above threshold |
| on_backup | input | 1 | 1 = running from backup power |
| wd_lvl | input | 2 | Decoded strobe: 00 low, 01 high, 1x mid |
| osc_ext | input | 1 | 1 = ticks from external clock |
| period_sel | input | 1 | Internal mode: 1 = long normal period |
| ce_in_n | input | 1 | Chip-enable request, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| low_line_n | output | 1 | Supply status, 0 = undervoltage |
| wd_ok | output | 1 | Watchdog status, 0 = timed out |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
A wrong count in the reset timer shows at `rst_out_n` as a release that comes one or more ticks early or late. This is seen on the first power-up. A lost grace flag shows as a timeout at the short limit right after release, so the first watchdog reset comes too early. A stale previous-level register either misses an edge or invents one. This shows at `wd_ok` and at the timeout reset within one normal period. A sticky flag that is not cleared shows at `wd_ok` one tick after the edge or the undervoltage that should clear it.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        WD_LOW     = 2'b00,
        WD_HIGH    = 2'b01,
        WD_MID     = 2'b10,
        WD_MID_ALT = 2'b11
    } wd_lvl_e;

    // Watchdog state other than the counter
    typedef struct packed {
        logic       grace;      // long timeout in force
        logic       timed_out;  // sticky timeout flag
        logic [1:0] prev;       // level seen on previous tick
    } wd_flags_t;

    function automatic logic lvl_is_mid(input logic [1:0] v);
        return v[1];
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
    parameter int unsigned RST_TICKS = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold_uv,
    input  logic wd_fire,
    output logic active
);
    localparam int unsigned W = $clog2(RST_TICKS + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (hold_uv || wd_fire) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt == W'(RST_TICKS - 1)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1: release only after the full width has been counted
    assert_pulse_len_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(cnt) == W'(RST_TICKS - 1)));

    // R1: undervoltage keeps the pulse going
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        hold_uv |=> active);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int unsigned EXT_SHORT = 1024,
    parameter int unsigned EXT_LONG  = 4096,
    parameter int unsigned INT_SHORT = 1024,
    parameter int unsigned INT_LONG  = 16384
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       hold,
    input  logic       uv,
    input  logic [1:0] wd_lvl,
    input  logic       osc_ext,
    input  logic       period_sel,
    output logic       fire,
    output logic       timed_out
);
    localparam int unsigned MAXL = max2(max2(EXT_SHORT, EXT_LONG), max2(INT_SHORT, INT_LONG));
    localparam int unsigned W    = $clog2(MAXL + 1);

    logic [W-1:0] cnt;
    wd_flags_t    st;
    logic [W-1:0] long_lim, norm_lim, limit;
    logic         cur_mid, edge_seen;

    always_comb begin
        long_lim  = osc_ext ? W'(EXT_LONG) : W'(INT_LONG);
        norm_lim  = osc_ext ? W'(EXT_SHORT) : (period_sel ? W'(INT_LONG) : W'(INT_SHORT));
        limit     = st.grace ? long_lim : norm_lim;
        cur_mid   = lvl_is_mid(wd_lvl);
        edge_seen = !cur_mid && !lvl_is_mid(st.prev) && (wd_lvl[0] != st.prev[0]);
        fire      = tick && !hold && !cur_mid && !edge_seen && (cnt == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            st  <= '{grace: 1'b1, timed_out: 1'b0, prev: WD_MID};
        end else begin
            if (tick) st.prev <= wd_lvl;
            if (uv) st.timed_out <= 1'b0;
            if (hold) begin
                cnt      <= '0;
                st.grace <= 1'b1;
            end else if (tick) begin
                if (cur_mid) begin
                    cnt          <= '0;
                    st.timed_out <= 1'b0;
                end else if (edge_seen) begin
                    cnt          <= '0;
                    st.grace     <= 1'b0;
                    st.timed_out <= 1'b0;
                end else if (fire) begin
                    cnt          <= '0;
                    st.timed_out <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign timed_out = st.timed_out;

    // R4: the flag is only raised by a timeout
    assert_flag_src_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(st.timed_out) |-> $past(fire));

    // R5: undervoltage clears the flag
    assert_uv_clear_R5: assert property (@(posedge clk) disable iff (rst)
        uv |=> !st.timed_out);

    // R6: mid level leaves no timeout pending
    assert_mid_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && cur_mid) |=> !st.timed_out);

    // R8: counter never passes the largest limit
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
        cnt < W'(MAXL));

endmodule

// File: rtl/proc_supervisor.sv
module proc_supervisor #(
    parameter int unsigned RST_TICKS = 512,
    parameter int unsigned EXT_SHORT = 1024,
    parameter int unsigned EXT_LONG  = 4096,
    parameter int unsigned INT_SHORT = 1024,
    parameter int unsigned INT_LONG  = 16384
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic       on_backup,
    input  logic [1:0] wd_lvl,
    input  logic       osc_ext,
    input  logic       period_sel,
    input  logic       ce_in_n,
    output logic       rst_out_n,
    output logic       rst_out,
    output logic       low_line_n,
    output logic       wd_ok,
    output logic       ce_out_n
);
    logic uv, rst_active, wd_fire, wd_flag;

    assign uv = !supply_ok || on_backup;

    sup_reset_gen #(.RST_TICKS(RST_TICKS)) u_rst (
        .clk(clk), .rst(rst), .tick(tick),
        .hold_uv(uv), .wd_fire(wd_fire), .active(rst_active)
    );

    sup_watchdog #(
        .EXT_SHORT(EXT_SHORT), .EXT_LONG(EXT_LONG),
        .INT_SHORT(INT_SHORT), .INT_LONG(INT_LONG)
    ) u_wd (
        .clk(clk), .rst(rst), .tick(tick),
        .hold(rst_active || uv), .uv(uv),
        .wd_lvl(wd_lvl), .osc_ext(osc_ext), .period_sel(period_sel),
        .fire(wd_fire), .timed_out(wd_flag)
    );

    assign rst_out    = rst_active || uv;
    assign rst_out_n  = !(rst_active || uv);
    assign low_line_n = supply_ok && !on_backup;
    assign wd_ok      = uv || !wd_flag;
    assign ce_out_n   = uv ? 1'b1 : ce_in_n;

    // R1: release happens only with a good supply
    assert_release_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> (supply_ok && !on_backup));

    // R2: outputs stay complementary
    assert_compl_R2: assert property (@(posedge clk) disable iff (rst)
        rst_out != rst_out_n);

    // R9: chip-enable blocked under undervoltage
    assert_ce_block_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> ce_out_n);

    // R10: backup mode gives reset and a high status
    assert_backup_R10: assert property (@(posedge clk) disable iff (rst)
        on_backup |-> (!rst_out_n && wd_ok && !low_line_n));

endmodule

// File: tb/sim_proc_supervisor.sv
module sim_proc_supervisor;
    localparam int unsigned RT = 8;
    localparam int unsigned ES = 16;
    localparam int unsigned EL = 64;
    localparam int unsigned IS = 24;
    localparam int unsigned IL = 48;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b1;
    logic supply_ok = 1'b0, on_backup = 1'b0, osc_ext = 1'b1, period_sel = 1'b0, ce_in_n = 1'b1;
    logic [1:0] wd_lvl = 2'b00;
    logic rst_out_n, rst_out, low_line_n, wd_ok, ce_out_n;
    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    proc_supervisor #(.RST_TICKS(RT), .EXT_SHORT(ES), .EXT_LONG(EL),
                      .INT_SHORT(IS), .INT_LONG(IL)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .on_backup(on_backup),
        .wd_lvl(wd_lvl), .osc_ext(osc_ext), .period_sel(period_sel), .ce_in_n(ce_in_n),
        .rst_out_n(rst_out_n), .rst_out(rst_out), .low_line_n(low_line_n),
        .wd_ok(wd_ok), .ce_out_n(ce_out_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drop supply, restore it and wait out the reset width; ends just after release edge
    task automatic power_cycle();
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(RT);
    endtask

    task automatic t_reset_state();
        supply_ok = 1'b1;
        step(3);
        chk("R1 reset during block reset", rst_out_n, 1'b0);
        chk("R5 status after block reset", wd_ok, 1'b1);
        rst = 1'b0;
    endtask

    task automatic t_powerup();
        supply_ok = 1'b0;
        step(2);
        chk("R1 reset under undervoltage", rst_out_n, 1'b0);
        chk("R2 complement low", rst_out, 1'b1);
        chk("R12 low-line status low", low_line_n, 1'b0);
        supply_ok = 1'b1;
        #1;
        chk("R12 low-line status high", low_line_n, 1'b1);
        step(RT - 1);
        chk("R1 still asserted one tick before end", rst_out_n, 1'b0);
        step(1);
        chk("R1 released after width", rst_out_n, 1'b1);
        chk("R2 complement high", rst_out, 1'b0);
    endtask

    task automatic t_grace_repeat();
        osc_ext = 1'b1; wd_lvl = 2'b00;
        power_cycle();
        step(EL - 1);
        chk("R7 no timeout before long period", rst_out_n, 1'b1);
        step(1);
        chk("R4 timeout asserts reset", rst_out_n, 1'b0);
        chk("R4 timeout status low", wd_ok, 1'b0);
        step(RT - 1);
        chk("R4 pulse width not yet over", rst_out_n, 1'b0);
        step(1);
        chk("R4 pulse width normal", rst_out_n, 1'b1);
        chk("R5 status stays low after pulse", wd_ok, 1'b0);
        step(EL - 1);
        chk("R11 no repeat before long period", rst_out_n, 1'b1);
        step(1);
        chk("R11 repeat after long period", rst_out_n, 1'b0);
        step(RT);
        wd_lvl = 2'b01;
        step(1);
        chk("R5 edge sets status high", wd_ok, 1'b1);
    endtask

    task automatic t_short_ext();
        osc_ext = 1'b1; wd_lvl = 2'b00;
        power_cycle();
        wd_lvl = 2'b01;
        step(1);
        step(ES - 4);
        wd_lvl = 2'b00;
        step(1);
        step(ES - 1);
        chk("R3 edge restarted count", rst_out_n, 1'b1);
        step(1);
        chk("R8 external short timeout", rst_out_n, 1'b0);
    endtask

    task automatic t_internal(input logic sel, input int unsigned norm);
        osc_ext = 1'b0; period_sel = sel; wd_lvl = 2'b00;
        power_cycle();
        step(IL - 1);
        chk("R7 internal grace not over", rst_out_n, 1'b1);
        step(1);
        chk("R7 internal grace is long", rst_out_n, 1'b0);
        step(RT);
        wd_lvl = 2'b01;
        step(1);
        step(norm - 1);
        chk("R8 internal normal not over", rst_out_n, 1'b1);
        step(1);
        chk("R8 internal normal timeout", rst_out_n, 1'b0);
        osc_ext = 1'b1; period_sel = 1'b0;
    endtask

    task automatic t_edges_in_reset();
        osc_ext = 1'b1; wd_lvl = 2'b00;
        supply_ok = 1'b0;
        step(2);
        supply_ok = 1'b1;
        step(2);
        wd_lvl = 2'b01;
        step(2);
        wd_lvl = 2'b00;
        step(RT - 4);
        chk("R1 release after toggling", rst_out_n, 1'b1);
        step(ES);
        chk("R7 edges in reset keep long timeout", rst_out_n, 1'b1);
        step(EL - ES);
        chk("R7 long timeout after reset edges", rst_out_n, 1'b0);
    endtask

    task automatic t_lowline_flag();
        osc_ext = 1'b1; wd_lvl = 2'b00;
        power_cycle();
        step(EL);
        chk("R4 timed out before undervoltage", wd_ok, 1'b0);
        supply_ok = 1'b0;
        #1;
        chk("R5 undervoltage forces status high", wd_ok, 1'b1);
        step(2);
        supply_ok = 1'b1;
        step(RT);
        chk("R5 flag cleared by undervoltage", wd_ok, 1'b1);
    endtask

    task automatic t_mid();
        wd_lvl = 2'b10;
        power_cycle();
        step(2 * EL + 5);
        chk("R6 no reset when mid", rst_out_n, 1'b1);
        chk("R6 status high when mid", wd_ok, 1'b1);
        wd_lvl = 2'b00;
        step(EL - 1);
        chk("R6 count starts on leaving mid", rst_out_n, 1'b1);
        step(2);
        chk("R6 watchdog active after mid", wd_ok, 1'b0);
        wd_lvl = 2'b11;
        step(RT + 2);
        chk("R6 mid clears status", wd_ok, 1'b1);
    endtask

    task automatic t_ce();
        power_cycle();
        ce_in_n = 1'b0; #1;
        chk("R9 ce follows low", ce_out_n, 1'b0);
        ce_in_n = 1'b1; #1;
        chk("R9 ce follows high", ce_out_n, 1'b1);
        ce_in_n = 1'b0; supply_ok = 1'b0; #1;
        chk("R9 ce blocked on undervoltage", ce_out_n, 1'b1);
        supply_ok = 1'b1; #1;
        chk("R9 ce follows after recovery", ce_out_n, 1'b0);
    endtask

    task automatic t_backup();
        wd_lvl = 2'b10;
        power_cycle();
        on_backup = 1'b1; #1;
        chk("R10 reset in backup", rst_out_n, 1'b0);
        chk("R10 ce high in backup", ce_out_n, 1'b1);
        chk("R10 status high in backup", wd_ok, 1'b1);
        chk("R10 low-line low in backup", low_line_n, 1'b0);
        wd_lvl = 2'b00; osc_ext = 1'b0;
        step(EL + IL);
        wd_lvl = 2'b01; osc_ext = 1'b1;
        step(3);
        chk("R10 still reset with inputs moving", rst_out_n, 1'b0);
        chk("R10 status unaffected by strobe", wd_ok, 1'b1);
        on_backup = 1'b0;
        step(RT - 1);
        chk("R10 width after backup", rst_out_n, 1'b0);
        step(1);
        chk("R10 release after backup", rst_out_n, 1'b1);
        ce_in_n = 1'b1;
    endtask

    initial begin
        t_reset_state();
        t_powerup();
        t_grace_repeat();
        t_short_ext();
        t_internal(1'b0, IS);
        t_internal(1'b1, IL);
        t_edges_in_reset();
        t_lowline_flag();
        t_mid();
        t_ce();
        t_backup();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule